// File: doc/BRIEF.md
# Reorder Buffer with Operand Wakeup

This block holds renamed instructions in a circular window and lets each slot act as a reservation station. A rename stage writes one instruction per cycle at the tail slot. Each instruction carries an opcode, two physical source tags with their values or a not-yet-valid flag, and a physical destination tag. Every slot watches one shared result broadcast, which one functional unit drives per cycle. When the broadcast tag equals a waiting source tag, the slot copies the value and marks that operand valid.

A slot that is live, has not been dispatched and holds both operands is ready. Among the ready slots the block offers the oldest one, counting from the head, on the issue port. When the functional unit accepts it, the slot is marked as executing and is not offered again. A later broadcast of the slot's destination tag stores the result and marks the slot complete. The head slot retires on its own as soon as it is complete. The commit port shows it during the cycle before the edge that frees it. Instructions therefore leave in program order, whatever order they finished in.

Top module: `rob_station`

## Requirements
- R1: After reset every slot is free: `ins_ready` is 1, `ins_idx` is 0, and `iss_valid` and `cmt_valid` are 0.
- R2: An accepted insertion is written into slot `ins_idx`, which equals the tail pointer. The tail advances by one per insertion and wraps from DEPTH-1 to 0.
- R3: `ins_ready` is 0 while the tail slot is still live. An insertion offered then is ignored and changes no slot.
- R4: A live slot whose source is not valid, and whose source tag equals a valid broadcast tag, captures the broadcast data as that operand and marks it valid at the next edge.
- R5: If an insertion's source tag is broadcast in the same cycle as the insertion, the operand is stored valid with the broadcast data.
- R6: `iss_valid` is 1 exactly when some slot is live, not yet dispatched, and has both operands valid. The issue port then shows that slot's operands and destination tag.
- R7: When several slots are ready, `iss_idx` names the first ready slot found when counting upward from the head pointer, modulo DEPTH.
- R8: `iss_take` with `iss_valid` marks the offered slot as dispatched at the edge, and that slot is not offered again.
- R9: A dispatched slot whose destination tag equals a valid broadcast tag stores the broadcast data as its result and becomes complete.
- R10: `cmt_valid` is 1 only while the head slot is complete, showing that slot's destination tag and result. At the next edge that slot is freed and the head advances, so retirement follows insertion order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insertion request |
| ins_op | input | OP_W | Opcode of the inserted instruction |
| ins_s1_tag | input | TAG_W | First source physical tag |
| ins_s1_ok | input | 1 | First source value already available |
| ins_s1_val | input | DATA_W | First source value |
| ins_s2_tag | input | TAG_W | Second source physical tag |
| ins_s2_ok | input | 1 | Second source value already available |
| ins_s2_val | input | DATA_W | Second source value |
| ins_dst_tag | input | TAG_W | Destination physical tag |
| ins_ready | output | 1 | Tail slot free, insertion accepted |
| ins_idx | output | PTR_W | Slot that the next insertion takes |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Broadcast destination tag |
| bc_data | input | DATA_W | Broadcast result value |
| iss_take | input | 1 | Functional unit accepts the offered slot |
| iss_valid | output | 1 | A ready slot is offered |
| iss_idx | output | PTR_W | Offered slot index |
| iss_op | output | OP_W | Offered opcode |
| iss_s1_val | output | DATA_W | Offered first operand |
| iss_s2_val | output | DATA_W | Offered second operand |
| iss_dst_tag | output | TAG_W | Offered destination tag |
| cmt_valid | output | 1 | Head slot complete, retiring this cycle |
| cmt_op | output | OP_W | Retiring opcode |
| cmt_dst_tag | output | TAG_W | Retiring destination tag |
| cmt_data | output | DATA_W | Retiring result value |

## Verification
Every output is decoded from registered slot state, so an insertion, broadcast or take shows its effect one edge after it is driven, with no combinational path from input to output. The bench drives each stimulus on a falling edge and checks the outputs on the next falling edge, after exactly one rising edge. A retirement is the exception, because it spans two edges. The completing broadcast makes `cmt_valid` visible after one edge, and the freed slot (`ins_ready`, the next head) is visible after the second edge, so those checks sample one cycle later.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  localparam int OP_W   = 4;
  localparam int TAG_W  = 6;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [TAG_W-1:0]  s1_tag;
    logic              s1_ok;
    logic [DATA_W-1:0] s1_val;
    logic [TAG_W-1:0]  s2_tag;
    logic              s2_ok;
    logic [DATA_W-1:0] s2_val;
    logic [TAG_W-1:0]  dst_tag;
  } rob_slot_t;

  typedef struct packed {
    logic              vld;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } rob_bcast_t;
endpackage

// File: rtl/rob_ring_ptrs.sv
`timescale 1ns/1ps
module rob_ring_ptrs #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o
);
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;

  always_comb begin
    head_d = head_q + PTR_W'(1);
    tail_d = tail_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (pop_i)  head_q <= head_d;
      if (push_i) tail_q <= tail_d;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
endmodule

// File: rtl/rob_age_pick.sv
`timescale 1ns/1ps
module rob_age_pick #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] head_i,
  input  logic [DEPTH-1:0] ready_i,
  output logic             any_o,
  output logic [PTR_W-1:0] sel_o,
  output logic [DEPTH-1:0] grant_o
);
  logic [PTR_W-1:0] idx;

  always_comb begin
    any_o   = 1'b0;
    sel_o   = '0;
    grant_o = '0;
    idx     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_i + PTR_W'(k);
      if (!any_o && ready_i[idx]) begin
        any_o        = 1'b1;
        sel_o        = idx;
        grant_o[idx] = 1'b1;
      end
    end
  end

  p_pick_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  p_pick_is_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ready_i[sel_o]);
endmodule

// File: rtl/rob_entry.sv
`timescale 1ns/1ps
module rob_entry
  import rob_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  rob_slot_t         alloc_data_i,
  input  rob_bcast_t        bc_i,
  input  logic              grant_i,
  input  logic              retire_i,
  output logic              use_o,
  output logic              ready_o,
  output logic              done_o,
  output rob_slot_t         slot_o,
  output logic [DATA_W-1:0] dval_o
);
  rob_slot_t         slot_q, slot_d;
  logic              use_q, use_d, exec_q, exec_d, done_q, done_d;
  logic [DATA_W-1:0] dval_q, dval_d;
  logic              en;

  always_comb begin
    slot_d = slot_q;
    use_d  = use_q;
    exec_d = exec_q;
    done_d = done_q;
    dval_d = dval_q;
    en     = alloc_i | use_q;
    if (alloc_i) begin
      slot_d = alloc_data_i;
      use_d  = 1'b1;
      exec_d = 1'b0;
      done_d = 1'b0;
      dval_d = '0;
    end
    if (en && bc_i.vld) begin
      if (!slot_d.s1_ok && bc_i.tag == slot_d.s1_tag) begin
        slot_d.s1_ok  = 1'b1;
        slot_d.s1_val = bc_i.data;
      end
      if (!slot_d.s2_ok && bc_i.tag == slot_d.s2_tag) begin
        slot_d.s2_ok  = 1'b1;
        slot_d.s2_val = bc_i.data;
      end
    end
    if (use_q && !alloc_i) begin
      if (grant_i) exec_d = 1'b1;
      if (exec_q && !done_q && bc_i.vld && bc_i.tag == slot_q.dst_tag) begin
        done_d = 1'b1;
        dval_d = bc_i.data;
      end
      if (retire_i) begin
        use_d  = 1'b0;
        exec_d = 1'b0;
        done_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      use_q  <= 1'b0;
      exec_q <= 1'b0;
      done_q <= 1'b0;
      dval_q <= '0;
    end else if (en) begin
      slot_q <= slot_d;
      use_q  <= use_d;
      exec_q <= exec_d;
      done_q <= done_d;
      dval_q <= dval_d;
    end
  end

  assign use_o   = use_q;
  assign ready_o = use_q & ~exec_q & slot_q.s1_ok & slot_q.s2_ok;
  assign done_o  = done_q;
  assign slot_o  = slot_q;
  assign dval_o  = dval_q;

  p_grant_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> (use_q && !exec_q && slot_q.s1_ok && slot_q.s2_ok));
  p_done_needs_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (exec_q && use_q));
  p_wakeup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (use_q && !alloc_i && !retire_i && !slot_q.s1_ok && bc_i.vld && bc_i.tag == slot_q.s1_tag)
    |=> (slot_q.s1_ok && slot_q.s1_val == $past(bc_i.data)));
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !alloc_data_i.s1_ok && bc_i.vld && bc_i.tag == alloc_data_i.s1_tag)
    |=> (slot_q.s1_ok && slot_q.s1_val == $past(bc_i.data)));
endmodule

// File: rtl/rob_station.sv
`timescale 1ns/1ps
module rob_station
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [OP_W-1:0]   ins_op,
  input  logic [TAG_W-1:0]  ins_s1_tag,
  input  logic              ins_s1_ok,
  input  logic [DATA_W-1:0] ins_s1_val,
  input  logic [TAG_W-1:0]  ins_s2_tag,
  input  logic              ins_s2_ok,
  input  logic [DATA_W-1:0] ins_s2_val,
  input  logic [TAG_W-1:0]  ins_dst_tag,
  output logic              ins_ready,
  output logic [PTR_W-1:0]  ins_idx,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              iss_take,
  output logic              iss_valid,
  output logic [PTR_W-1:0]  iss_idx,
  output logic [OP_W-1:0]   iss_op,
  output logic [DATA_W-1:0] iss_s1_val,
  output logic [DATA_W-1:0] iss_s2_val,
  output logic [TAG_W-1:0]  iss_dst_tag,
  output logic              cmt_valid,
  output logic [OP_W-1:0]   cmt_op,
  output logic [TAG_W-1:0]  cmt_dst_tag,
  output logic [DATA_W-1:0] cmt_data
);
  logic [PTR_W-1:0]  head, tail, sel;
  logic [DEPTH-1:0]  use_v, ready_v, done_v, grant_v;
  rob_slot_t         slot_v [DEPTH];
  logic [DATA_W-1:0] dval_v [DEPTH];
  rob_slot_t         ins_slot;
  rob_bcast_t        bc;
  logic              push, retire, any;

  assign ins_slot = '{op: ins_op, s1_tag: ins_s1_tag, s1_ok: ins_s1_ok, s1_val: ins_s1_val,
                      s2_tag: ins_s2_tag, s2_ok: ins_s2_ok, s2_val: ins_s2_val,
                      dst_tag: ins_dst_tag};
  assign bc       = '{vld: bc_valid, tag: bc_tag, data: bc_data};

  assign ins_ready = ~use_v[tail];
  assign ins_idx   = tail;
  assign push      = ins_valid & ins_ready;
  assign retire    = use_v[head] & done_v[head];

  rob_ring_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(retire),
    .head_o(head), .tail_o(tail)
  );

  rob_age_pick #(.DEPTH(DEPTH)) pick_i (
    .clk(clk), .rst_n(rst_n), .head_i(head), .ready_i(ready_v),
    .any_o(any), .sel_o(sel), .grant_o(grant_v)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rob_entry ent_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(push && tail == PTR_W'(g)),
      .alloc_data_i(ins_slot),
      .bc_i(bc),
      .grant_i(grant_v[g] & iss_take),
      .retire_i(retire && head == PTR_W'(g)),
      .use_o(use_v[g]), .ready_o(ready_v[g]), .done_o(done_v[g]),
      .slot_o(slot_v[g]), .dval_o(dval_v[g])
    );
  end

  assign iss_valid   = any;
  assign iss_idx     = sel;
  assign iss_op      = slot_v[sel].op;
  assign iss_s1_val  = slot_v[sel].s1_val;
  assign iss_s2_val  = slot_v[sel].s2_val;
  assign iss_dst_tag = slot_v[sel].dst_tag;

  assign cmt_valid   = retire;
  assign cmt_op      = slot_v[head].op;
  assign cmt_dst_tag = slot_v[head].dst_tag;
  assign cmt_data    = dval_v[head];

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |=> $stable(tail));
  p_retire_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !use_v[$past(head)]);
endmodule

// File: tb/rob_station_tb.sv
`timescale 1ns/1ps
module rob_station_tb_top;
  import rob_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ins_valid, ins_s1_ok, ins_s2_ok;
  logic [OP_W-1:0]   ins_op;
  logic [TAG_W-1:0]  ins_s1_tag, ins_s2_tag, ins_dst_tag;
  logic [DATA_W-1:0] ins_s1_val, ins_s2_val;
  logic              ins_ready;
  logic [2:0]        ins_idx;
  logic              bc_valid;
  logic [TAG_W-1:0]  bc_tag;
  logic [DATA_W-1:0] bc_data;
  logic              iss_take, iss_valid;
  logic [2:0]        iss_idx;
  logic [OP_W-1:0]   iss_op, cmt_op;
  logic [DATA_W-1:0] iss_s1_val, iss_s2_val, cmt_data;
  logic [TAG_W-1:0]  iss_dst_tag, cmt_dst_tag;
  logic              cmt_valid;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rob_station dut_i (.*);

  typedef struct packed {
    logic ins; logic [5:0] s1t; logic s1k; logic [15:0] s1v;
    logic [5:0] s2t; logic s2k; logic [15:0] s2v; logic [5:0] dst;
    logic bcv; logic [5:0] bct; logic [15:0] bcd; logic take;
    logic e_iv; logic [2:0] e_idx; logic [15:0] e_s1;
    logic e_cv; logic [5:0] e_cdst; logic [15:0] e_cd;
  } vec_t;

  // ins s1t s1k s1v s2t s2k s2v dst | bcv bct bcd take | exp iv idx s1 cv cdst cdata
  localparam vec_t VECS [9] = '{
    '{1'b1,6'd1,1'b0,16'h0,6'd2,1'b1,16'h5,6'd10, 1'b0,6'd0,16'h0,1'b0, 1'b0,3'd0,16'h0, 1'b0,6'd0,16'h0},
    '{1'b1,6'd3,1'b1,16'h7,6'd4,1'b1,16'h8,6'd11, 1'b0,6'd0,16'h0,1'b0, 1'b1,3'd1,16'h7, 1'b0,6'd0,16'h0},
    '{1'b0,6'd0,1'b0,16'h0,6'd0,1'b0,16'h0,6'd0,  1'b1,6'd1,16'h20,1'b0, 1'b1,3'd0,16'h20, 1'b0,6'd0,16'h0},
    '{1'b1,6'd12,1'b0,16'h0,6'd2,1'b1,16'h1,6'd13, 1'b1,6'd12,16'h33,1'b1, 1'b1,3'd1,16'h7, 1'b0,6'd0,16'h0},
    '{1'b0,6'd0,1'b0,16'h0,6'd0,1'b0,16'h0,6'd0,  1'b0,6'd0,16'h0,1'b1, 1'b1,3'd2,16'h33, 1'b0,6'd0,16'h0},
    '{1'b0,6'd0,1'b0,16'h0,6'd0,1'b0,16'h0,6'd0,  1'b1,6'd11,16'h44,1'b0, 1'b1,3'd2,16'h33, 1'b0,6'd0,16'h0},
    '{1'b0,6'd0,1'b0,16'h0,6'd0,1'b0,16'h0,6'd0,  1'b1,6'd10,16'h55,1'b0, 1'b1,3'd2,16'h33, 1'b1,6'd10,16'h55},
    '{1'b0,6'd0,1'b0,16'h0,6'd0,1'b0,16'h0,6'd0,  1'b0,6'd0,16'h0,1'b0, 1'b1,3'd2,16'h33, 1'b1,6'd11,16'h44},
    '{1'b0,6'd0,1'b0,16'h0,6'd0,1'b0,16'h0,6'd0,  1'b0,6'd0,16'h0,1'b0, 1'b1,3'd2,16'h33, 1'b0,6'd0,16'h0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 0; ins_op = 4'h3; ins_s1_tag = 0; ins_s1_ok = 0; ins_s1_val = 0;
    ins_s2_tag = 0; ins_s2_ok = 0; ins_s2_val = 0; ins_dst_tag = 0;
    bc_valid = 0; bc_tag = 0; bc_data = 0; iss_take = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic put(input logic [5:0] t1, input logic k1, input logic [15:0] v1,
                     input logic [5:0] t2, input logic k2, input logic [15:0] v2,
                     input logic [5:0] d);
    ins_valid = 1; ins_s1_tag = t1; ins_s1_ok = k1; ins_s1_val = v1;
    ins_s2_tag = t2; ins_s2_ok = k2; ins_s2_val = v2; ins_dst_tag = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "ins_ready", 32'(ins_ready), 32'd1);
    chk("R1", "ins_idx", 32'(ins_idx), 32'd0);
    chk("R1", "iss_valid", 32'(iss_valid), 32'd0);
    chk("R1", "cmt_valid", 32'(cmt_valid), 32'd0);

    // table: wakeup R4, bypass R5, issue R6/R8, age R7, complete R9, in-order commit R10
    for (int i = 0; i < 9; i++) begin
      vec_t v = VECS[i];
      idle();
      if (v.ins) put(v.s1t, v.s1k, v.s1v, v.s2t, v.s2k, v.s2v, v.dst);
      bc_valid = v.bcv; bc_tag = v.bct; bc_data = v.bcd; iss_take = v.take;
      step();
      idle();
      chk("R6", $sformatf("row%0d iss_valid", i), 32'(iss_valid), 32'(v.e_iv));
      if (v.e_iv) begin
        chk("R7", $sformatf("row%0d iss_idx", i), 32'(iss_idx), 32'(v.e_idx));
        chk("R4", $sformatf("row%0d iss_s1_val", i), 32'(iss_s1_val), 32'(v.e_s1));
      end
      chk("R10", $sformatf("row%0d cmt_valid", i), 32'(cmt_valid), 32'(v.e_cv));
      if (v.e_cv) begin
        chk("R10", $sformatf("row%0d cmt_dst", i), 32'(cmt_dst_tag), 32'(v.e_cdst));
        chk("R9", $sformatf("row%0d cmt_data", i), 32'(cmt_data), 32'(v.e_cd));
      end
    end

    // fill, overflow, wrap
    do_reset();
    for (int i = 0; i < 8; i++) begin
      chk("R2", "ins_idx before insert", 32'(ins_idx), 32'(i));
      put(6'd50, 1'b0, 16'h0, 6'd50, 1'b0, 16'h0, 6'(20 + i));
      step();
      idle();
    end
    chk("R3", "ins_ready when full", 32'(ins_ready), 32'd0);
    chk("R2", "ins_idx wrapped", 32'(ins_idx), 32'd0);
    put(6'd1, 1'b1, 16'h9, 6'd2, 1'b1, 16'h9, 6'd60);
    step();
    idle();
    chk("R3", "insert while full ignored", 32'(iss_valid), 32'd0);
    bc_valid = 1; bc_tag = 6'd50; bc_data = 16'h77;
    step();
    idle();
    chk("R4", "both sources woken", 32'(iss_valid), 32'd1);
    chk("R7", "oldest is head", 32'(iss_idx), 32'd0);
    chk("R4", "captured operand", 32'(iss_s2_val), 32'h77);
    iss_take = 1;
    step();
    idle();
    chk("R8", "taken slot not offered again", 32'(iss_idx), 32'd1);
    bc_valid = 1; bc_tag = 6'd20; bc_data = 16'h99;
    step();
    idle();
    chk("R9", "head complete", 32'(cmt_valid), 32'd1);
    chk("R9", "result stored", 32'(cmt_data), 32'h99);
    chk("R10", "retiring dst", 32'(cmt_dst_tag), 32'd20);
    step();
    chk("R10", "slot freed after retire", 32'(ins_ready), 32'd1);
    chk("R10", "next head not complete", 32'(cmt_valid), 32'd0);
    chk("R2", "insert goes to wrapped slot", 32'(ins_idx), 32'd0);
    put(6'd3, 1'b1, 16'h3, 6'd4, 1'b1, 16'h4, 6'd30);
    step();
    idle();
    chk("R7", "age order wraps from head", 32'(iss_idx), 32'd1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule